// File: doc/BRIEF.md
# Desaturation Fault Protection Sequencer

This block is the digital sequencer for an isolated power-transistor gate driver. It follows a PWM command and drives the high-side and low-side enables of the output stage. After every turn-on it masks the collector-desaturation comparator for a programmable number of cycles. After that it watches the comparator for as long as the gate is commanded on. When the gate is commanded off, the comparator is never looked at. On normal turn-off the low driver pulls the gate down first. The Miller clamp engages only after a settling interval, when the gate has fallen close to the negative rail.

When desaturation is seen, the sequencer releases the main output to high impedance and runs a slow soft-shutdown discharge. It then holds the output muted with the clamp on, whatever the command does. After a configurable delay it pulls the active-low fault line down. The fault clears only when the command has stayed low for a full reset interval after the mute. Only then does the output follow the command again.

A supply-good flag blocks turn-on and cuts short an on phase. A latched fault stays latched through a supply drop. All intervals are counted in clock cycles and set by parameters. A parameter selects either a one-hot or a binary state encoding.

Top module: `desat_guard`

## Requirements
- R1: While reset is asserted and right after it, the outputs show the idle-off state: low enable 1, clamp 1, fault_n 1, and high enable, high-impedance and soft-shutdown all 0.
- R2: A high command, sampled with supply_ok high in idle-off, sets the high enable from the next cycle on. For the first BLANK_CYC sampled cycles of the on phase, desat_in is ignored.
- R3: desat_in acts only while the command is high after blanking. If the command is low in the same sample as desat_in, the block takes the normal turn-off path and raises no fault.
- R4: A fault gives SSD_CYC cycles of high-impedance with soft-shutdown enabled. It is followed by MUTE_CYC cycles of high-impedance with the clamp on. All command and desat_in activity is ignored during both phases.
- R5: fault_n falls FLT_DLY cycles after the first soft-shutdown cycle and stays low until the fault clears.
- R6: After the mute, the low enable and clamp are on. The fault clears and idle-off returns once the command has been sampled low RESET_CYC times in a row. A high sample restarts this count from zero.
- R7: A command falling while on gives CLAMP_CYC cycles with only the low enable set, during which the command is ignored. Idle-off with the clamp follows.
- R8: supply_ok low blocks turn-on and ends an on phase through the normal turn-off path. It wins over desat_in in the same sample. It neither clears a latched fault nor stops the fault sequence.
- R9: The one-hot and binary encodings (ONEHOT = 1 or 0) give identical port behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Gate command, high means on |
| desat_in | input | 1 | Desaturation comparator flag |
| supply_ok | input | 1 | Output-side supply above its lockout level |
| drv_hi_en | output | 1 | Source driver enable |
| drv_lo_en | output | 1 | Sink driver enable |
| drv_hiz | output | 1 | Main output released to high impedance |
| ssd_en | output | 1 | Soft-shutdown discharge enable |
| clamp_en | output | 1 | Miller clamp enable |
| fault_n | output | 1 | Fault indication, active low |

## Verification
The sharpest collisions are a desaturation flag arriving in the same sample as either a falling command or a supply drop. In both cases turn-off must win and no fault may latch. The stimulus table places desat_in high exactly on the cycle where pwm_in falls, and again on the cycle where supply_ok falls. It then checks that the low-only drain state follows, with fault_n still high. A third overlap is a supply drop in the middle of the fault sequence. There the bench checks that the fault_n timing and the mute length are unchanged.

// File: rtl/desat_guard.sv
module desat_guard #(
  parameter int BLANK_CYC = 60,
  parameter int SSD_CYC   = 600,
  parameter int MUTE_CYC  = 230000,
  parameter int RESET_CYC = 230000,
  parameter int FLT_DLY   = 700,
  parameter int CLAMP_CYC = 20,
  parameter bit ONEHOT    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic desat_in,
  input  logic supply_ok,
  output logic drv_hi_en,
  output logic drv_lo_en,
  output logic drv_hiz,
  output logic ssd_en,
  output logic clamp_en,
  output logic fault_n
);

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXC = mx(mx(mx(BLANK_CYC, SSD_CYC), mx(MUTE_CYC, RESET_CYC)), mx(CLAMP_CYC, FLT_DLY));
  localparam int CW   = $clog2(MAXC + 1);
  localparam int SW   = ONEHOT ? 7 : 3;

  function automatic logic [SW-1:0] enc(int i);
    return ONEHOT ? SW'(1 << i) : SW'(i);
  endfunction

  localparam logic [SW-1:0] ST_IDLE  = enc(0);
  localparam logic [SW-1:0] ST_BLANK = enc(1);
  localparam logic [SW-1:0] ST_ON    = enc(2);
  localparam logic [SW-1:0] ST_SSD   = enc(3);
  localparam logic [SW-1:0] ST_MUTE  = enc(4);
  localparam logic [SW-1:0] ST_WAIT  = enc(5);
  localparam logic [SW-1:0] ST_DRAIN = enc(6);

  logic [SW-1:0] st, st_nx;
  logic [CW-1:0] cnt, lim, dcnt;
  logic          flt;
  logic          done;

  always_comb begin
    case (st)
      ST_BLANK: lim = CW'(BLANK_CYC);
      ST_SSD:   lim = CW'(SSD_CYC);
      ST_MUTE:  lim = CW'(MUTE_CYC);
      ST_WAIT:  lim = CW'(RESET_CYC);
      ST_DRAIN: lim = CW'(CLAMP_CYC);
      default:  lim = CW'(1);
    endcase
  end

  assign done = (cnt == lim - 1'b1);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (pwm_in && supply_ok) st_nx = ST_BLANK;
      ST_BLANK: if (!pwm_in || !supply_ok) st_nx = ST_DRAIN;
                else if (done) st_nx = ST_ON;
      ST_ON:    if (!pwm_in || !supply_ok) st_nx = ST_DRAIN;
                else if (desat_in) st_nx = ST_SSD;
      ST_SSD:   if (done) st_nx = ST_MUTE;
      ST_MUTE:  if (done) st_nx = ST_WAIT;
      ST_WAIT:  if (!pwm_in && done) st_nx = ST_IDLE;
      ST_DRAIN: if (done) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st || (st == ST_WAIT && pwm_in))
        cnt <= '0;
      else if (!done)
        cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt  <= 1'b0;
      dcnt <= '0;
    end else if (st_nx == ST_SSD && st != ST_SSD) begin
      flt  <= 1'b1;
      dcnt <= '0;
    end else if (st == ST_WAIT && st_nx == ST_IDLE) begin
      flt  <= 1'b0;
    end else if (flt && dcnt != CW'(FLT_DLY)) begin
      dcnt <= dcnt + 1'b1;
    end
  end

  assign drv_hi_en = (st == ST_BLANK) || (st == ST_ON);
  assign drv_lo_en = (st == ST_IDLE) || (st == ST_DRAIN) || (st == ST_WAIT);
  assign drv_hiz   = (st == ST_SSD) || (st == ST_MUTE);
  assign ssd_en    = (st == ST_SSD);
  assign clamp_en  = (st == ST_IDLE) || (st == ST_MUTE) || (st == ST_WAIT);
  assign fault_n   = !(flt && dcnt == CW'(FLT_DLY));

  // R8
  supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !drv_hi_en);

  // R2
  turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_hi_en) |-> $past(pwm_in) && $past(supply_ok) && fault_n);

  // R3
  desat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_hiz) |-> $past(desat_in) && $past(pwm_in) && $past(drv_hi_en));

  // R4
  mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_hiz |=> !drv_hi_en);

  // R5
  fault_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> !drv_hi_en && (drv_hiz || clamp_en));

  // R6
  fault_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> !$past(pwm_in) && !drv_hi_en && !drv_hiz);

  generate
    if (ONEHOT) begin : g_oh
      // R9
      onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(st));
    end
  endgenerate

endmodule

// File: tb/test_desat_guard.sv
`timescale 1ns/1ps
module test_desat_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0, desat_in = 1'b0, supply_ok = 1'b1;
  logic hi_a, lo_a, hiz_a, ssd_a, clm_a, fn_a;
  logic hi_b, lo_b, hiz_b, ssd_b, clm_b, fn_b;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  desat_guard #(.BLANK_CYC(3), .SSD_CYC(3), .MUTE_CYC(4), .RESET_CYC(3),
                .FLT_DLY(2), .CLAMP_CYC(2), .ONEHOT(1'b1)) i_desat_guard (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .desat_in(desat_in), .supply_ok(supply_ok),
    .drv_hi_en(hi_a), .drv_lo_en(lo_a), .drv_hiz(hiz_a), .ssd_en(ssd_a),
    .clamp_en(clm_a), .fault_n(fn_a));

  desat_guard #(.BLANK_CYC(3), .SSD_CYC(3), .MUTE_CYC(4), .RESET_CYC(3),
                .FLT_DLY(2), .CLAMP_CYC(2), .ONEHOT(1'b0)) i_desat_guard_bin (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .desat_in(desat_in), .supply_ok(supply_ok),
    .drv_hi_en(hi_b), .drv_lo_en(lo_b), .drv_hiz(hiz_b), .ssd_en(ssd_b),
    .clamp_en(clm_b), .fault_n(fn_b));

  // expected {hi, lo, hiz, ssd, clamp, fault_n}
  localparam logic [5:0] E_IDLE = 6'b010011, E_ON = 6'b100001, E_DRN = 6'b010001;
  localparam logic [5:0] E_SSD1 = 6'b001101, E_SSD0 = 6'b001100;
  localparam logic [5:0] E_MUTE = 6'b001010, E_WAIT = 6'b010010;

  // {req, pwm, desat, supply_ok, expected}
  localparam logic [12:0] VEC [54] = '{
    {4'd1, 3'b001, E_IDLE},                                                        // R1
    {4'd2, 3'b111, E_ON}, {4'd2, 3'b111, E_ON}, {4'd2, 3'b111, E_ON}, {4'd2, 3'b111, E_ON}, // R2 blanking
    {4'd3, 3'b011, E_DRN},                                                         // R3 same-sample off
    {4'd7, 3'b001, E_DRN}, {4'd7, 3'b101, E_IDLE},                                 // R7
    {4'd2, 3'b101, E_ON}, {4'd2, 3'b101, E_ON}, {4'd2, 3'b101, E_ON}, {4'd2, 3'b101, E_ON},
    {4'd4, 3'b111, E_SSD1}, {4'd4, 3'b001, E_SSD1}, {4'd5, 3'b101, E_SSD0},        // R4 R5
    {4'd4, 3'b101, E_MUTE}, {4'd4, 3'b011, E_MUTE}, {4'd4, 3'b111, E_MUTE}, {4'd4, 3'b001, E_MUTE},
    {4'd6, 3'b101, E_WAIT}, {4'd6, 3'b101, E_WAIT}, {4'd6, 3'b001, E_WAIT},        // R6
    {4'd6, 3'b001, E_WAIT}, {4'd6, 3'b101, E_WAIT}, {4'd6, 3'b001, E_WAIT},
    {4'd6, 3'b001, E_WAIT}, {4'd6, 3'b001, E_IDLE},
    {4'd2, 3'b101, E_ON},
    {4'd8, 3'b100, E_DRN}, {4'd8, 3'b100, E_DRN}, {4'd8, 3'b100, E_IDLE}, {4'd8, 3'b100, E_IDLE}, // R8
    {4'd8, 3'b101, E_ON}, {4'd2, 3'b101, E_ON}, {4'd2, 3'b101, E_ON}, {4'd2, 3'b101, E_ON},
    {4'd8, 3'b110, E_DRN},                                                         // R8 supply beats desat
    {4'd7, 3'b001, E_DRN}, {4'd7, 3'b001, E_IDLE},
    {4'd2, 3'b101, E_ON}, {4'd2, 3'b101, E_ON}, {4'd2, 3'b101, E_ON}, {4'd2, 3'b101, E_ON},
    {4'd4, 3'b111, E_SSD1}, {4'd8, 3'b100, E_SSD1}, {4'd5, 3'b100, E_SSD0},        // R8 fault kept
    {4'd8, 3'b100, E_MUTE}, {4'd8, 3'b100, E_MUTE}, {4'd8, 3'b100, E_MUTE}, {4'd8, 3'b100, E_MUTE},
    {4'd8, 3'b000, E_WAIT}, {4'd8, 3'b000, E_WAIT}, {4'd8, 3'b000, E_WAIT},
    {4'd6, 3'b000, E_IDLE}
  };

  task automatic chk(input int req, input logic [5:0] got, input logic [5:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got %b expected %b at %0t", req, tag, got, exp, $time);
    end
  endtask

  task automatic chk_both(input int req, input logic [5:0] exp);
    chk(req, {hi_a, lo_a, hiz_a, ssd_a, clm_a, fn_a}, exp, "onehot");
    // R9 binary encoding must match
    chk(req, {hi_b, lo_b, hiz_b, ssd_b, clm_b, fn_b}, exp, "binary R9");
  endtask

  task automatic step(input logic p, input logic d, input logic s);
    @(negedge clk);
    pwm_in = p; desat_in = d; supply_ok = s;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk_both(1, E_IDLE);                          // R1 reset state
    @(negedge clk);
    rst_n = 1'b1;
    foreach (VEC[i]) begin
      step(VEC[i][8], VEC[i][7], VEC[i][6]);
      chk_both(int'(VEC[i][12:9]), VEC[i][5:0]);
    end
    // R1: reset in the middle of a latched fault
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    chk_both(4, E_SSD1);
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    chk_both(5, E_SSD0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_both(1, E_IDLE);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b1);
    chk_both(2, E_ON);                            // R2 follows after reset
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule